// File: doc/BRIEF.md
# Sequential Next-Block Prefetch Unit for an Instruction Cache

This unit sits beside an instruction cache and handles every cache miss. For a miss on a block that it does not hold, it asks next-level memory for two blocks: the missed block and the one after it. The missed block goes into the cache. The block after it is kept in a one-entry stream buffer and is not written into the cache.

When the cache later misses on the buffered block, the unit delivers that block from the buffer and does not go to memory. It then asks memory for the next block in sequence, which refills the buffer. A sequential instruction stream therefore pays the memory latency only on its first miss.

Demand fetches always come before prefetches. A prefetch that is waiting to be accepted is withdrawn when a new miss arrives. A prefetch already in flight for the missed address is waited for, so the same address is never requested twice. All addresses are block addresses. Memory returns one whole block per response, in request order. A request is taken in any cycle where `mem_req_valid` and `mem_req_ready` are both high.

Top module: `sbp_prefetch`

## Requirements
- R1: While reset is applied and just after it is released, `miss_ready` is 1, `fill_valid` is 0 and `mem_req_valid` is 0, and the stream buffer is empty.
- R2: A miss on block address A that is neither buffered nor in flight requests A from memory first and A+1 right after.
- R3: A demand response is delivered as a one-cycle `fill_valid` pulse in the cycle after the response, with `fill_addr` = A and `fill_data` equal to the returned block.
- R4: The response to a prefetch is kept in the stream buffer and produces no fill, so each miss produces exactly one fill.
- R5: A miss on the buffered address is accepted at once and filled in the next cycle from the buffer, with no memory request in the accepting cycle and no request for that address.
- R6: After a buffer hit on address B, exactly one request follows, for B+1.
- R7: A miss on any other address empties the buffer. A later miss on the formerly buffered address is then fetched from memory again.
- R8: When a miss is accepted, an unaccepted prefetch request is withdrawn in that cycle. The demand address is presented next, and the prefetch is not reissued before the demand request has been taken.
- R9: A miss on an address whose prefetch is already in flight issues no duplicate request. The prefetch response itself becomes the fill, including when it arrives in the same cycle as the miss.
- R10: `miss_ready` is 0 from the cycle after a demand miss is accepted until its fill has been produced.
- R11: Block addresses wrap modulo 2^AW, so the block after the highest address is address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a miss; held until `miss_ready` |
| miss_addr | input | AW | Block address of the miss |
| miss_ready | output | 1 | Unit can accept a miss this cycle |
| fill_valid | output | 1 | One-cycle pulse: block to write into the cache |
| fill_addr | output | AW | Block address of the fill |
| fill_data | output | BW | Block contents of the fill |
| mem_req_valid | output | 1 | Request to next-level memory |
| mem_req_addr | output | AW | Block address requested |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_rsp_valid | input | 1 | Memory returns a block (in request order) |
| mem_rsp_data | input | BW | Returned block |

## Verification
Two events can fall in the same cycle: a miss is accepted on an address whose prefetch is in flight, and memory returns that same prefetch. The bench provokes this by presenting the next sequential miss immediately after each demand fill. It sweeps the memory latency from one to five cycles, which moves the prefetch return to before, at and after the cycle in which the second miss is accepted. In every case the outcome is judged by two things: the miss must receive exactly one fill carrying the correct block, and the request log must contain three consecutive addresses with no duplicate.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
   // Marks each memory request so its in-order response can be routed.
   typedef enum logic {
      TAG_DEMAND   = 1'b0,
      TAG_PREFETCH = 1'b1
   } sbp_tag_e;
endpackage

// File: rtl/sbp_tag_fifo.sv
module sbp_tag_fifo
   import sbp_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     push,
   input  sbp_tag_e push_tag,
   input  logic     pop,
   output sbp_tag_e head_tag,
   output logic     full,
   output logic     empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = PW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sbp_tag_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   sbp_tag_e         slots [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;

   assign full     = (count == CW'(DEPTH));
   assign empty    = (count == '0);
   assign head_tag = slots[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            slots[wr_ptr] <= push_tag;
            wr_ptr        <= wr_ptr + 1'b1;
         end
         if (pop) rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end
endmodule

// File: rtl/sbp_stream_buf.sv
module sbp_stream_buf #(
   parameter int AW = 16,
   parameter int BW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic [BW-1:0] load_data,
   input  logic          clear,
   input  logic [AW-1:0] look_addr,
   output logic          hit,
   output logic [BW-1:0] data
);
   logic          held;
   logic [AW-1:0] held_addr;

   assign hit = held && (held_addr == look_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_addr <= '0;
         data      <= '0;
      end else if (clear) begin
         held <= 1'b0;
      end else if (load) begin
         held      <= 1'b1;
         held_addr <= load_addr;
         data      <= load_data;
      end
   end
endmodule

// File: rtl/sbp_prefetch.sv
module sbp_prefetch
   import sbp_pkg::*;
#(
   parameter int AW = 16,
   parameter int BW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          miss_valid,
   input  logic [AW-1:0] miss_addr,
   output logic          miss_ready,
   output logic          fill_valid,
   output logic [AW-1:0] fill_addr,
   output logic [BW-1:0] fill_data,
   output logic          mem_req_valid,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_req_ready,
   input  logic          mem_rsp_valid,
   input  logic [BW-1:0] mem_rsp_data
);
   // At most one demand and one prefetch can be outstanding together.
   localparam int OUTSTANDING = 2;

   generate
      if (AW < 1 || BW < 1) begin : g_bad_width
         $error("sbp_prefetch: AW and BW must be positive");
      end
   endgenerate

   logic          dem_req, dem_wait, pf_to_cache;
   logic          pf_want, pf_inflight, pf_live;
   logic [AW-1:0] cur_addr, pf_next, pf_fly;

   logic          busy, accept, acc_sb, acc_fly, acc_new;
   logic          pf_issue, req_fire, rsp_dem, rsp_pf, pf_direct;
   logic          sb_hit, sb_load, sb_clear;
   logic [BW-1:0] sb_data;
   logic          tf_push, tf_full, tf_empty;
   sbp_tag_e      tf_head;

   assign busy       = dem_req | dem_wait | pf_to_cache;
   assign miss_ready = !busy;
   assign accept     = miss_valid & !busy;
   assign acc_sb     = accept & sb_hit;
   assign acc_fly    = accept & !sb_hit & pf_inflight & pf_live & (miss_addr == pf_fly);
   assign acc_new    = accept & !sb_hit & !acc_fly;

   // Demand first; a waiting prefetch steps aside for a miss being accepted.
   assign pf_issue      = pf_want & !pf_inflight & !dem_req & !accept;
   assign mem_req_valid = dem_req | pf_issue;
   assign mem_req_addr  = dem_req ? cur_addr : pf_next;
   assign req_fire      = mem_req_valid & mem_req_ready;
   assign tf_push       = req_fire;

   assign rsp_dem   = mem_rsp_valid & (tf_head == TAG_DEMAND);
   assign rsp_pf    = mem_rsp_valid & (tf_head == TAG_PREFETCH);
   assign pf_direct = rsp_pf & pf_live & (pf_to_cache | acc_fly);
   assign sb_load   = rsp_pf & pf_live & !pf_direct;
   assign sb_clear  = acc_sb | acc_new;

   sbp_tag_fifo #(.DEPTH(OUTSTANDING)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (tf_push),
      .push_tag (dem_req ? TAG_DEMAND : TAG_PREFETCH),
      .pop      (mem_rsp_valid),
      .head_tag (tf_head),
      .full     (tf_full),
      .empty    (tf_empty)
   );

   sbp_stream_buf #(.AW(AW), .BW(BW)) u_sbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sb_load),
      .load_addr (pf_fly),
      .load_data (mem_rsp_data),
      .clear     (sb_clear),
      .look_addr (miss_addr),
      .hit       (sb_hit),
      .data      (sb_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dem_req     <= 1'b0;
         dem_wait    <= 1'b0;
         pf_to_cache <= 1'b0;
         pf_want     <= 1'b0;
         pf_inflight <= 1'b0;
         pf_live     <= 1'b0;
         cur_addr    <= '0;
         pf_next     <= '0;
         pf_fly      <= '0;
         fill_valid  <= 1'b0;
         fill_addr   <= '0;
         fill_data   <= '0;
      end else begin
         fill_valid <= 1'b0;
         if (acc_sb) begin
            fill_valid <= 1'b1;
            fill_addr  <= miss_addr;
            fill_data  <= sb_data;
            pf_want    <= 1'b1;
            pf_next    <= miss_addr + 1'b1;
         end
         if (rsp_dem) begin
            fill_valid <= 1'b1;
            fill_addr  <= cur_addr;
            fill_data  <= mem_rsp_data;
            dem_wait   <= 1'b0;
         end
         if (pf_direct) begin
            fill_valid  <= 1'b1;
            fill_addr   <= pf_fly;
            fill_data   <= mem_rsp_data;
            pf_to_cache <= 1'b0;
            pf_want     <= 1'b1;
            pf_next     <= pf_fly + 1'b1;
         end
         if (req_fire && dem_req) begin
            dem_req  <= 1'b0;
            dem_wait <= 1'b1;
         end
         if (req_fire && !dem_req) begin
            pf_inflight <= 1'b1;
            pf_live     <= 1'b1;
            pf_fly      <= pf_next;
            pf_want     <= 1'b0;
         end
         if (rsp_pf) pf_inflight <= 1'b0;
         if (acc_fly && !rsp_pf) pf_to_cache <= 1'b1;
         if (acc_new) begin
            cur_addr <= miss_addr;
            dem_req  <= 1'b1;
            pf_want  <= 1'b1;
            pf_next  <= miss_addr + 1'b1;
            pf_live  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sbp_prefetch_chk.sv
module sbp_prefetch_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          miss_valid,
   input logic          miss_ready,
   input logic [AW-1:0] miss_addr,
   input logic          fill_valid,
   input logic [AW-1:0] fill_addr,
   input logic          mem_req_valid,
   input logic [AW-1:0] mem_req_addr,
   input logic          mem_req_ready,
   input logic          mem_rsp_valid,
   input logic          sb_hit,
   input logic          acc_new,
   input logic          dem_req,
   input logic          tf_push,
   input logic          tf_full,
   input logic          tf_empty
);
   assert_bufhit_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready && sb_hit) |=> (fill_valid && fill_addr == $past(miss_addr)));

   assert_bufhit_nomem_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready && sb_hit) |-> !mem_req_valid);

   assert_demand_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_new |=> (mem_req_valid && mem_req_addr == $past(miss_addr)));

   assert_busy_after_demand_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready && dem_req) |=> !miss_ready);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(tf_push && tf_full));

   assert_rsp_expected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> !tf_empty);
endmodule

bind sbp_prefetch sbp_prefetch_chk #(.AW(AW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .miss_valid    (miss_valid),
   .miss_ready    (miss_ready),
   .miss_addr     (miss_addr),
   .fill_valid    (fill_valid),
   .fill_addr     (fill_addr),
   .mem_req_valid (mem_req_valid),
   .mem_req_addr  (mem_req_addr),
   .mem_req_ready (mem_req_ready),
   .mem_rsp_valid (mem_rsp_valid),
   .sb_hit        (sb_hit),
   .acc_new       (acc_new),
   .dem_req       (dem_req),
   .tf_push       (tf_push),
   .tf_full       (tf_full),
   .tf_empty      (tf_empty)
);

// File: tb/sim_sbp_prefetch.sv
`timescale 1ns/1ps
module sim_sbp_prefetch;
   localparam int AW = 6;
   localparam int BW = 16;
   localparam int AM = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [AW-1:0] miss_addr = '0;
   logic          miss_ready;
   logic          fill_valid;
   logic [AW-1:0] fill_addr;
   logic [BW-1:0] fill_data;
   logic          mem_req_valid;
   logic [AW-1:0] mem_req_addr;
   logic          mem_req_ready = 1'b1;
   logic          mem_rsp_valid = 1'b0;
   logic [BW-1:0] mem_rsp_data = '0;

   always #2.5 clk = ~clk;

   sbp_prefetch #(.AW(AW), .BW(BW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   int total = 0, fails = 0;
   int cyc = 0;
   int lat = 2;
   int req_n = 0;
   int req_log [0:1023];
   int q_a [0:15];
   int q_t [0:15];
   int q_wr = 0, q_rd = 0;
   int fill_n = 0, last_fill_addr = 0, last_fill_data = 0, last_fill_cyc = 0;

   function automatic int blk(int a);
      return (a * 40503 + 4660) & 16'hFFFF;
   endfunction

   // Memory model: log and queue every accepted request.
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         req_log[req_n % 1024] <= int'(mem_req_addr);
         req_n                 <= req_n + 1;
         q_a[q_wr % 16]        <= int'(mem_req_addr);
         q_t[q_wr % 16]        <= cyc;
         q_wr                  <= q_wr + 1;
      end
   end

   // In-order responses, one block each, after lat cycles.
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (q_rd < q_wr && cyc >= q_t[q_rd % 16] + lat) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = BW'(blk(q_a[q_rd % 16]));
         q_rd          = q_rd + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && fill_valid) begin
         fill_n         = fill_n + 1;
         last_fill_addr = int'(fill_addr);
         last_fill_data = int'(fill_data);
         last_fill_cyc  = cyc;
      end
   end

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle;
      repeat (14) step;
   endtask

   // mode 0: fresh demand miss, 1: buffer hit expected, 2: no timing claim
   task automatic do_miss(input int a, input int mode);
      int n0, c, t;
      n0 = fill_n;
      miss_addr  = AW'(a % AM);
      miss_valid = 1'b1;
      t = 0;
      while (!miss_ready && t < 300) begin step; t++; end
      c = cyc;
      step;
      miss_valid = 1'b0;
      if (mode == 1) chk(fill_n == n0 + 1 && last_fill_cyc == c + 1, "R5 fill cycle", last_fill_cyc, c + 1);
      if (mode == 0) chk(!miss_ready, "R10 busy after demand", int'(miss_ready), 0);
      t = 0;
      while (fill_n == n0 && t < 300) begin step; t++; end
      chk(last_fill_addr == a % AM, "R3 fill addr", last_fill_addr, a % AM);
      chk(last_fill_data == blk(a % AM), "R3 fill data", last_fill_data, blk(a % AM));
   endtask

   task automatic check_reqs(input int r0, input int cnt, input int a0, input string req);
      chk(req_n - r0 == cnt, req, req_n - r0, cnt);
      if (req_n - r0 == cnt)
         for (int k = 0; k < cnt; k++)
            chk(req_log[(r0 + k) % 1024] == (a0 + k) % AM, req, req_log[(r0 + k) % 1024], (a0 + k) % AM);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      int r0, f0;
      repeat (3) step;
      chk(miss_ready && !fill_valid && !mem_req_valid, "R1 during reset", int'(mem_req_valid), 0);
      rst_n = 1'b1;
      step;
      chk(miss_ready == 1'b1, "R1 ready", int'(miss_ready), 1);
      chk(!fill_valid && !mem_req_valid, "R1 idle", int'(fill_valid) + int'(mem_req_valid), 0);
      // R1: buffer empty, so the first miss must go to memory.
      r0 = req_n;
      do_miss(5, 0);
      settle;
      check_reqs(r0, 2, 5, "R1 empty buffer -> R2 order");

      // R8: demand overtakes a waiting prefetch.
      lat = 3;
      mem_req_ready = 1'b0;
      r0 = req_n;
      miss_addr = AW'(40);
      miss_valid = 1'b1;
      step;
      miss_valid = 1'b0;
      chk(mem_req_valid && mem_req_addr == AW'(40), "R2 demand presented", int'(mem_req_addr), 40);
      mem_req_ready = 1'b1;
      step;
      mem_req_ready = 1'b0;
      step;
      chk(mem_req_valid && mem_req_addr == AW'(41), "R8 prefetch waiting", int'(mem_req_addr), 41);
      f0 = fill_n;
      for (int t = 0; t < 50 && fill_n == f0; t++) step;
      miss_addr = AW'(50);
      miss_valid = 1'b1;
      #1;
      chk(!mem_req_valid, "R8 prefetch withdrawn", int'(mem_req_valid), 0);
      step;
      miss_valid = 1'b0;
      chk(mem_req_valid && mem_req_addr == AW'(50), "R8 demand next", int'(mem_req_addr), 50);
      mem_req_ready = 1'b1;
      settle;
      chk(req_n - r0 == 3, "R8 request count", req_n - r0, 3);
      chk(req_log[(r0 + 1) % 1024] == 50 && req_log[(r0 + 2) % 1024] == 51,
          "R8 order", req_log[(r0 + 1) % 1024], 50);

      // Sweep latencies and start points (62 exercises R11 wrap).
      for (int l = 1; l <= 5; l++) begin
         for (int si = 0; si < 3; si++) begin
            int s;
            s = (si == 0) ? 0 : (si == 1) ? 21 : 62;
            lat = l;
            r0 = req_n; f0 = fill_n;
            do_miss(s, 0);
            settle;
            check_reqs(r0, 2, s, "R2 miss pair");
            chk(fill_n == f0 + 1, "R4 one fill per miss", fill_n - f0, 1);
            for (int k = 1; k <= 3; k++) begin
               r0 = req_n;
               do_miss(s + k, 1);
               settle;
               check_reqs(r0, 1, s + k + 1, "R6 R11 next prefetch");
            end
            // R9: second miss chases the prefetch in flight.
            r0 = req_n; f0 = fill_n;
            do_miss(s + 10, 0);
            do_miss(s + 11, 2);
            settle;
            check_reqs(r0, 3, s + 10, "R9 no duplicate");
            chk(fill_n == f0 + 2, "R9 fill count", fill_n - f0, 2);
            // R7: unrelated miss drops the buffered block (s+12).
            do_miss(s + 30, 0);
            settle;
            r0 = req_n;
            do_miss(s + 12, 0);
            settle;
            check_reqs(r0, 2, s + 12, "R7 buffer invalidated");
         end
      end
      finish_run();
   end
endmodule